// File: doc/BRIEF.md
# Ping-Pong Bulk OUT Receive Buffer with DMA Request

This block holds the receive side of a bulk OUT endpoint. It has two byte banks, and each bank holds one packet. The packet side writes bytes into the banks in turn and marks where each packet ends. A processor or a DMA engine drains the bank that is selected for reading. Releasing a bank hands it back to the packet side and moves the read selection to the other bank. Packets therefore leave the block in the order they arrived.

There are two ways to release a bank, chosen by a DMA enable input:
- **Software mode (DMA enable low):** the drained bank stays selected until a read-done pulse arrives.
- **DMA mode (DMA enable high):** the block releases the bank by itself when the last byte of the packet is read, whatever the packet length.

A request-select input picks which of two active-low request lines carries the DMA request. The request is asserted while any complete packet waits in the buffer. A read-done pulse given during DMA mode is misuse. It still releases a bank, and it leaves a sticky flag so the fault can be seen.

Top module: `rxpp_ep_buf`

## Requirements
- R1: There are two banks of DEPTH (default 64) bytes each. Bytes are read back in the order they were written, and packets are read back in the order they were completed.
- R2: A packet closes when a byte is accepted with `wr_last` high, or when the bank's DEPTH-th byte is accepted. The next accepted byte starts a packet in the other bank.
- R3: `wr_ready` is low while the bank due to be written still holds a complete packet, which happens when both banks hold packets. A byte offered while `wr_ready` is low is dropped and does not change any stored data.
- R4: A read strobe that finds a byte available presents that byte on `rd_data` in the cycle after the strobe.
- R5: With DMA disabled, once every byte of the selected packet has been read, further read strobes return 0 and do not move to the next packet. A `rd_done` pulse releases the selected bank, discarding any unread bytes, and selects the other bank.
- R6: With DMA enabled, reading the last byte of the selected packet releases that bank and selects the other one. This holds for every packet length from 1 to DEPTH.
- R7: The request lines are registered. One cycle after the buffer holds a complete packet with DMA enabled, the line chosen by `req_sel` goes low: `req_sel`=0 uses `dreq0_n` and `req_sel`=1 uses `dreq1_n`. The line that is not chosen stays high. Both lines are high one cycle after both banks are empty, and both are high whenever DMA is disabled.
- R8: A read strobe that finds nothing readable returns 0 on `rd_data` in the next cycle and sets the sticky `underrun` output. Only reset clears `underrun`.
- R9: A `rd_done` pulse while DMA is enabled still releases the selected bank, if that bank holds a packet. This is an extra release. The pulse also sets the sticky `misuse` output.
- R10: After reset, both banks are empty, `wr_ready` is 1, both request lines are 1, `rd_data` is 0, and both flags are 0.
- R11: With DMA enabled, a 150-byte transfer that arrives as packets of 64, 64 and 22 bytes is read back in full with exactly three automatic releases. After that, a further read returns 0 and both request lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Packet side offers a byte |
| wr_data | input | DATA_W | Offered byte |
| wr_last | input | 1 | Offered byte ends the packet |
| wr_ready | output | 1 | Bank due to be written can accept bytes |
| rd_en | input | 1 | Read strobe from the CPU or DMA side |
| rd_data | output | DATA_W | Byte read, valid the cycle after the strobe |
| rd_done | input | 1 | Software release strobe |
| dma_en | input | 1 | Enables DMA mode and the request output |
| req_sel | input | 1 | Chooses which request line is driven |
| dreq0_n | output | 1 | Active-low request, line 0 |
| dreq1_n | output | 1 | Active-low request, line 1 |
| underrun | output | 1 | Sticky: a read found nothing to return |
| misuse | output | 1 | Sticky: release strobe seen in DMA mode |

## Verification
The assertions assume the following about the inputs:
- `wr_last` is sampled only together with an accepted byte.
- `dma_en` and `req_sel` change only between packets, never while a bank is partly drained.

The stimulus meets these assumptions. Mode and line are set before each packet is pushed. The packet side never offers a byte it expects to be dropped, except in the one directed check of R3.

The checks on the release strobe in DMA mode use that strobe deliberately. They judge the outcome by the `misuse` flag and by the read data, not by any assumption about correct use.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  // Which release sources fired in a cycle: bit 1 = software strobe, bit 0 = automatic.
  typedef enum logic [1:0] {
    REL_NONE   = 2'b00,
    REL_AUTO   = 2'b01,
    REL_MANUAL = 2'b10,
    REL_BOTH   = 2'b11
  } rel_src_e;

  function automatic rel_src_e rel_kind(input logic manual, input logic auto_hit);
    return rel_src_e'({manual, auto_hit});
  endfunction

endpackage

// File: rtl/rxpp_store.sv
module rxpp_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Simple dual-port memory with a registered read port, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxpp_bank.sv
module rxpp_bank #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_byte,
  input  logic             wr_close,
  input  logic             rd_step,
  input  logic             release_i,
  output logic             full,
  output logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] rptr,
  output logic [CNT_W-1:0] wcnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      len  <= '0;
      rptr <= '0;
      wcnt <= '0;
    end else begin
      if (wr_byte) begin
        if (wr_close) begin
          full <= 1'b1;
          len  <= wcnt + 1'b1;
          wcnt <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
      if (release_i) begin
        full <= 1'b0;
        rptr <= '0;
      end else if (rd_step) begin
        rptr <= rptr + 1'b1;
      end
    end
  end

  AST_BANK_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    wr_byte |-> !full); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    full |-> (len != '0 && len <= CNT_W'(DEPTH))); // R2
  AST_RPTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    full |-> (rptr <= len)); // R5
  AST_STEP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    rd_step |-> full); // R1

endmodule

// File: rtl/rxpp_req.sv
module rxpp_req #(
  parameter int NUM_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dma_en,
  input  logic                 req_sel,
  input  logic                 any_full,
  output logic [NUM_LINES-1:0] dreq_n
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) dreq_n[g] <= 1'b1;
      else     dreq_n[g] <= !(dma_en && any_full && (32'(req_sel) == g));
    end
  end

  AST_REQ_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dreq_n)); // R7
  AST_REQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!any_full || !dma_en) |=> (&dreq_n)); // R7

endmodule

// File: rtl/rxpp_ep_buf.sv
module rxpp_ep_buf
  import rxpp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_done,
  input  logic              dma_en,
  input  logic              req_sel,
  output logic              dreq0_n,
  output logic              dreq1_n,
  output logic              underrun,
  output logic              misuse
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = PTR_W + 1;
  localparam int BANKS  = 2;

  logic             wsel, rsel;
  logic [BANKS-1:0] full;
  logic [CNT_W-1:0] len  [BANKS];
  logic [CNT_W-1:0] rptr [BANKS];
  logic [CNT_W-1:0] wcnt [BANKS];

  logic wr_fire, wr_end, rd_ok, last_rd, auto_rel, man_rel, rel;
  logic rd_zero;
  logic [DATA_W-1:0] ram_q;
  logic [1:0] dreq_n;
  rel_src_e rel_src;

  // Write side
  assign wr_ready = !full[wsel];
  assign wr_fire  = wr_valid && wr_ready;
  assign wr_end   = wr_fire && (wr_last || (wcnt[wsel] == CNT_W'(DEPTH - 1)));

  // Read side and release
  assign rd_ok    = rd_en && full[rsel] && (rptr[rsel] != len[rsel]);
  assign last_rd  = rd_ok && (CNT_W'(rptr[rsel] + 1'b1) == len[rsel]);
  assign auto_rel = dma_en && last_rd;
  assign man_rel  = rd_done && full[rsel];
  assign rel_src  = rel_kind(man_rel, auto_rel);
  assign rel      = (rel_src != REL_NONE);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    rxpp_bank #(.DEPTH(DEPTH), .CNT_W(CNT_W)) bank_i (
      .clk       (clk),
      .rst       (rst),
      .wr_byte   (wr_fire && (32'(wsel) == b)),
      .wr_close  (wr_end  && (32'(wsel) == b)),
      .rd_step   (rd_ok   && (32'(rsel) == b)),
      .release_i (rel     && (32'(rsel) == b)),
      .full      (full[b]),
      .len       (len[b]),
      .rptr      (rptr[b]),
      .wcnt      (wcnt[b])
    );
  end

  rxpp_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
    .clk   (clk),
    .we    (wr_fire),
    .waddr ({wsel, wcnt[wsel][PTR_W-1:0]}),
    .wdata (wr_data),
    .re    (rd_ok),
    .raddr ({rsel, rptr[rsel][PTR_W-1:0]}),
    .rdata (ram_q)
  );

  rxpp_req #(.NUM_LINES(2)) req_i (
    .clk      (clk),
    .rst      (rst),
    .dma_en   (dma_en),
    .req_sel  (req_sel),
    .any_full (|full),
    .dreq_n   (dreq_n)
  );

  assign dreq0_n = dreq_n[0];
  assign dreq1_n = dreq_n[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel     <= 1'b0;
      rsel     <= 1'b0;
      underrun <= 1'b0;
      misuse   <= 1'b0;
      rd_zero  <= 1'b1;
    end else begin
      if (wr_end) wsel <= !wsel;
      if (rel)    rsel <= !rsel;
      if (rd_en && !rd_ok)  underrun <= 1'b1;
      if (rd_done && dma_en) misuse <= 1'b1;
      if (rd_en) rd_zero <= !rd_ok;
    end
  end

  assign rd_data = rd_zero ? '0 : ram_q;

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (&full) |-> !wr_ready); // R3
  AST_AUTO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (dma_en && last_rd) |=> (rsel != $past(rsel))); // R6
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dma_en && !rd_done) |=> $stable(rsel)); // R5
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun); // R8
  AST_ZERO_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_ok) |=> (rd_data == '0)); // R8
  AST_MISUSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_done && dma_en) |=> misuse); // R9
  AST_WSEL_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !wr_end) |=> $stable(wsel)); // R2

endmodule

// File: tb/rxpp_ep_buf_tb_top.sv
module rxpp_ep_buf_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_valid, wr_last, wr_ready;
  logic [7:0] wr_data;
  logic       rd_en, rd_done, dma_en, req_sel;
  logic [7:0] rd_data;
  logic       dreq0_n, dreq1_n, underrun, misuse;

  int checks = 0;
  int errors = 0;

  always #10 clk = !clk;

  rxpp_ep_buf #(.DATA_W(8), .DEPTH(64)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data), .rd_done(rd_done),
    .dma_en(dma_en), .req_sel(req_sel), .dreq0_n(dreq0_n), .dreq1_n(dreq1_n),
    .underrun(underrun), .misuse(misuse)
  );

  // Each entry: [8] DMA enable, [7] request line, [6:0] packet length
  localparam logic [8:0] VEC [6] = '{9'h140, 9'h181, 9'h016, 9'h0C0, 9'h125, 9'h001};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_pkt(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 8'(seed + i);
      wr_last  = (i == n - 1);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic read_chk(input string req, input int exp);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, "rd_data", int'(rd_data), exp);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL ALL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_valid = 1'b0; wr_last = 1'b0; wr_data = '0;
    rd_en = 1'b0; rd_done = 1'b0; dma_en = 1'b0; req_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk("R10", "wr_ready", int'(wr_ready), 1);
    chk("R10", "dreq0_n", int'(dreq0_n), 1);
    chk("R10", "dreq1_n", int'(dreq1_n), 1);
    chk("R10", "rd_data", int'(rd_data), 0);
    chk("R10", "underrun", int'(underrun), 0);
    chk("R10", "misuse", int'(misuse), 0);

    // Vector walk: R1 R4 R6 R7 R5
    foreach (VEC[k]) begin
      int n;
      logic d, s;
      d = VEC[k][8]; s = VEC[k][7]; n = int'(VEC[k][6:0]);
      dma_en = d; req_sel = s;
      push_pkt(n, 16 * k + 3);
      @(negedge clk);
      chk("R7", "dreq0_n with packet", int'(dreq0_n), (d && !s) ? 0 : 1);
      chk("R7", "dreq1_n with packet", int'(dreq1_n), (d && s) ? 0 : 1);
      for (int i = 0; i < n; i++) read_chk("R1", 8'(16 * k + 3 + i));
      if (d) begin
        @(negedge clk);
        chk("R6", "dreq0_n after drain", int'(dreq0_n), 1);
        chk("R6", "dreq1_n after drain", int'(dreq1_n), 1);
        chk("R6", "wr_ready after auto release", int'(wr_ready), 1);
      end else begin
        pulse_done();
        chk("R5", "wr_ready after rd_done", int'(wr_ready), 1);
      end
    end

    // R2 / R3: 70 bytes with one end marker -> 64 + 6; both banks full
    dma_en = 1'b1; req_sel = 1'b0;
    push_pkt(70, 8'h40);
    chk("R3", "wr_ready both full", int'(wr_ready), 0);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    for (int i = 0; i < 70; i++) read_chk("R2", 8'(8'h40 + i));
    @(negedge clk);
    chk("R3", "dreq0_n after dropped write", int'(dreq0_n), 1);

    // R5 / R8: software mode, hold after drain, discard on release
    dma_en = 1'b0;
    push_pkt(3, 8'h80);
    push_pkt(2, 8'h90);
    @(negedge clk);
    chk("R7", "dreq0_n dma off", int'(dreq0_n), 1);
    for (int i = 0; i < 3; i++) read_chk("R5", 8'h80 + i);
    read_chk("R5", 0);
    chk("R8", "underrun", int'(underrun), 1);
    pulse_done();
    read_chk("R5", 8'h90);
    read_chk("R5", 8'h91);
    pulse_done();
    push_pkt(5, 8'hA0);
    push_pkt(2, 8'hB0);
    read_chk("R5", 8'hA0);
    read_chk("R5", 8'hA1);
    pulse_done();
    read_chk("R5", 8'hB0);
    read_chk("R5", 8'hB1);
    pulse_done();
    chk("R8", "underrun still set", int'(underrun), 1);

    // R9: release strobe in DMA mode releases an extra bank
    dma_en = 1'b1;
    push_pkt(2, 8'hC0);
    push_pkt(2, 8'hD0);
    read_chk("R9", 8'hC0);
    read_chk("R9", 8'hC1);
    chk("R9", "misuse before strobe", int'(misuse), 0);
    pulse_done();
    chk("R9", "misuse after strobe", int'(misuse), 1);
    read_chk("R9", 0);
    @(negedge clk);
    chk("R9", "dreq0_n both released", int'(dreq0_n), 1);
    chk("R9", "wr_ready", int'(wr_ready), 1);

    // R11: 150 bytes as 64 + 64 + 22 on line 1
    req_sel = 1'b1;
    push_pkt(64, 0);
    push_pkt(64, 64);
    @(negedge clk);
    chk("R11", "dreq1_n pending", int'(dreq1_n), 0);
    chk("R11", "dreq0_n unused", int'(dreq0_n), 1);
    for (int i = 0; i < 64; i++) read_chk("R11", i);
    push_pkt(22, 128);
    for (int i = 64; i < 150; i++) read_chk("R11", i);
    read_chk("R11", 0);
    @(negedge clk);
    chk("R11", "dreq1_n done", int'(dreq1_n), 1);
    chk("R11", "dreq0_n done", int'(dreq0_n), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule